// File: doc/BRIEF.md
# Iterative Multiply/Divide Engine with Result-Pair Interlock

This block performs signed and unsigned integer multiplication and division over two operands, one bit per clock, and keeps the outcome in a private pair of result registers named HI and LO. A command carries a 6-bit function code and two operands. A multiply or divide command launches an operation that runs on its own, beside the main pipeline. During that time `busy` stays high. A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO.

Requests that read HI or LO are interlocked against a running operation. While the engine is busy, such a request is answered with `rd_stall`, and the requester holds its command. Once the engine is idle, the request gets `rd_ready` in the same cycle, with the selected register on `rd_data`. Requests that write HI or LO take operand A directly into the chosen register. Both datapaths work on operand magnitudes and apply the sign at the end. Division truncates toward zero.

Top module: `muldiv_unit`

## Requirements
- R1: Function codes are MULT=24, MULTU=25, DIV=26, DIVU=27, MFHI=16, MTHI=17, MFLO=18, MTLO=19 (decimal, on `cmd_func`). After reset HI and LO are zero and `busy` is low.
- R2: A multiply (24 signed, 25 unsigned) leaves bits 63:32 of the 64-bit product of A and B in HI and bits 31:0 in LO.
- R3: A divide (26 signed, 27 unsigned) with a nonzero divisor leaves quotient A/B in LO and the remainder in HI. The signed quotient truncates toward zero, and the signed remainder takes the sign of A. The case -2^31 / -1 gives quotient 0x80000000 and remainder 0.
- R4: `busy` rises in the cycle after an accepted multiply or divide and stays high for exactly 32 cycles. The results are readable from the first cycle in which `busy` is low.
- R5: A move-from command (16 or 18) gives `rd_stall`=1 and `rd_ready`=0 while `busy` is high. When `busy` is low it gives `rd_ready`=1 in the same cycle, with HI (16) or LO (18) on `rd_data`. `rd_data` is zero whenever `rd_ready` is low.
- R6: A move-to command (17 to HI, 19 to LO) loads A into that register at the next clock and leaves the other register unchanged. If it arrives in the cycle in which an operation completes, the move-to value wins for its register.
- R7: A divide by zero completes in the normal 32 cycles without any trap. It leaves LO = 0xFFFFFFFF and HI = operand A, for both signed and unsigned divides.
- R8: A multiply or divide accepted while `busy` is high aborts the running operation, which writes nothing, and restarts the 32-cycle count for the new operation.
- R9: A command with `cmd_valid` low, or with a function code outside the eight listed, changes neither HI, LO nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_func | input | 6 | Function code of the command |
| cmd_a | input | DATA_W | Operand A (dividend, multiplicand, move-to data) |
| cmd_b | input | DATA_W | Operand B (divisor, multiplier) |
| busy | output | 1 | Multiply or divide in progress |
| rd_ready | output | 1 | Move-from request served this cycle |
| rd_stall | output | 1 | Move-from request held off by a running operation |
| rd_data | output | DATA_W | Selected HI or LO value when `rd_ready` is high, else zero |

## Verification
The assertions check several properties on every cycle:
- the partial remainder of the divider stays below the divisor magnitude;
- the multiplier's upper accumulator never exceeds the multiplicand;
- `busy` falls only after the last of 32 iterations;
- a move-from request is never served while the engine is busy;
- HI keeps its value when nothing writes it;
- a move-to lands on the next edge.

Only the bench's scenarios can show that the products, quotients and remainders are correct for both signednesses, including the overflow quotient and the divide-by-zero values. The scenarios also cover an abort midway through an operation and a move-to colliding with a completion.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    parameter int FUNC_W = 6;

    localparam logic [FUNC_W-1:0] FN_MFHI  = 6'd16;
    localparam logic [FUNC_W-1:0] FN_MTHI  = 6'd17;
    localparam logic [FUNC_W-1:0] FN_MFLO  = 6'd18;
    localparam logic [FUNC_W-1:0] FN_MTLO  = 6'd19;
    localparam logic [FUNC_W-1:0] FN_MULT  = 6'd24;
    localparam logic [FUNC_W-1:0] FN_MULTU = 6'd25;
    localparam logic [FUNC_W-1:0] FN_DIV   = 6'd26;
    localparam logic [FUNC_W-1:0] FN_DIVU  = 6'd27;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MUL  = 2'd1,
        ENG_DIV  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic go_mul;
        logic go_div;
        logic sgn;
        logic put_hi;
        logic put_lo;
        logic get;
        logic get_hi;
    } md_cmd_t;

    function automatic md_cmd_t md_decode(input logic [FUNC_W-1:0] f);
        md_cmd_t d;
        d = '0;
        case (f)
            FN_MULT:  begin d.go_mul = 1'b1; d.sgn = 1'b1; end
            FN_MULTU: d.go_mul = 1'b1;
            FN_DIV:   begin d.go_div = 1'b1; d.sgn = 1'b1; end
            FN_DIVU:  d.go_div = 1'b1;
            FN_MFHI:  begin d.get = 1'b1; d.get_hi = 1'b1; end
            FN_MFLO:  d.get = 1'b1;
            FN_MTHI:  d.put_hi = 1'b1;
            FN_MTLO:  d.put_lo = 1'b1;
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mul_core.sv
module mul_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         sgn,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    localparam int PW = 2 * W;

    logic [W-1:0] acc_hi_q, acc_lo_q, mcand_q;
    logic         neg_q;

    logic         a_neg, b_neg;
    logic [W-1:0] a_mag, b_mag;
    logic [W:0]   sum;
    logic [W-1:0] nxt_hi, nxt_lo;
    logic [PW-1:0] prod, prod_fix;

    always_comb begin
        a_neg = sgn & op_a[W-1];
        b_neg = sgn & op_b[W-1];
        a_mag = a_neg ? -op_a : op_a;
        b_mag = b_neg ? -op_b : op_b;
        sum    = {1'b0, acc_hi_q} + (acc_lo_q[0] ? {1'b0, mcand_q} : '0);
        nxt_hi = sum[W:1];
        nxt_lo = {sum[0], acc_lo_q[W-1:1]};
        prod     = {nxt_hi, nxt_lo};
        prod_fix = neg_q ? -prod : prod;
        res_hi   = prod_fix[PW-1:W];
        res_lo   = prod_fix[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi_q <= '0;
            acc_lo_q <= '0;
            mcand_q  <= '0;
            neg_q    <= 1'b0;
        end else if (load) begin
            acc_hi_q <= '0;
            acc_lo_q <= b_mag;
            mcand_q  <= a_mag;
            neg_q    <= a_neg ^ b_neg;
        end else if (step) begin
            acc_hi_q <= nxt_hi;
            acc_lo_q <= nxt_lo;
        end
    end

    // R2
    mul_acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_hi_q <= mcand_q)
        else $error("upper accumulator exceeded multiplicand");

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         sgn,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    logic [W-1:0] rem_q, quo_q, dvsr_q, dvd_q;
    logic         qneg_q, rneg_q, dz_q;

    logic         a_neg, b_neg;
    logic [W-1:0] a_mag, b_mag;
    logic [W:0]   shifted, diff;
    logic         fits;
    logic [W-1:0] nrem, nquo;

    always_comb begin
        a_neg   = sgn & op_a[W-1];
        b_neg   = sgn & op_b[W-1];
        a_mag   = a_neg ? -op_a : op_a;
        b_mag   = b_neg ? -op_b : op_b;
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dvsr_q};
        fits    = ~diff[W];
        nrem    = fits ? diff[W-1:0] : shifted[W-1:0];
        nquo    = {quo_q[W-2:0], fits};
        if (dz_q) begin
            res_hi = dvd_q;
            res_lo = '1;
        end else begin
            res_hi = rneg_q ? -nrem : nrem;
            res_lo = qneg_q ? -nquo : nquo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
            dvd_q  <= '0;
            qneg_q <= 1'b0;
            rneg_q <= 1'b0;
            dz_q   <= 1'b1;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= a_mag;
            dvsr_q <= b_mag;
            dvd_q  <= op_a;
            qneg_q <= a_neg ^ b_neg;
            rneg_q <= a_neg;
            dz_q   <= (op_b == '0);
        end else if (step) begin
            rem_q <= nrem;
            quo_q <= nquo;
        end
    end

    // R3
    div_rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !dz_q |-> (rem_q < dvsr_q))
        else $error("partial remainder not below divisor");

endmodule

// File: rtl/hilo_file.sv
module hilo_file #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pair_we,
    input  logic [W-1:0] pair_hi,
    input  logic [W-1:0] pair_lo,
    input  logic         hi_we,
    input  logic         lo_we,
    input  logic [W-1:0] mv_data,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_we)        hi_q <= mv_data;
            else if (pair_we) hi_q <= pair_hi;
            if (lo_we)        lo_q <= mv_data;
            else if (pair_we) lo_q <= pair_lo;
        end
    end

    // R9
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pair_we && !hi_we) |=> $stable(hi_q))
        else $error("HI changed without a write");

    // R9
    lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pair_we && !lo_we) |=> $stable(lo_q))
        else $error("LO changed without a write");

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_func,
    input  logic [DATA_W-1:0] cmd_a,
    input  logic [DATA_W-1:0] cmd_b,
    output logic              busy,
    output logic              rd_ready,
    output logic              rd_stall,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    md_cmd_t      cmd;
    eng_state_e   eng_q;
    logic [CNT_W-1:0] cnt_q;
    logic         start, finish;
    logic [DATA_W-1:0] mul_hi, mul_lo, div_hi, div_lo;
    logic [DATA_W-1:0] res_hi, res_lo, hi_q, lo_q;

    always_comb begin
        cmd    = cmd_valid ? md_decode(cmd_func) : '0;
        start  = cmd.go_mul | cmd.go_div;
        busy   = (eng_q != ENG_IDLE);
        finish = busy && (cnt_q == LAST) && !start;
        res_hi = (eng_q == ENG_MUL) ? mul_hi : div_hi;
        res_lo = (eng_q == ENG_MUL) ? mul_lo : div_lo;
        rd_ready = cmd.get && !busy;
        rd_stall = cmd.get && busy;
        rd_data  = rd_ready ? (cmd.get_hi ? hi_q : lo_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q <= ENG_IDLE;
            cnt_q <= '0;
        end else if (start) begin
            eng_q <= cmd.go_mul ? ENG_MUL : ENG_DIV;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST) eng_q <= ENG_IDLE;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end

    mul_core #(.W(DATA_W)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .load   (cmd.go_mul),
        .step   (eng_q == ENG_MUL),
        .sgn    (cmd.sgn),
        .op_a   (cmd_a),
        .op_b   (cmd_b),
        .res_hi (mul_hi),
        .res_lo (mul_lo)
    );

    div_core #(.W(DATA_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .load   (cmd.go_div),
        .step   (eng_q == ENG_DIV),
        .sgn    (cmd.sgn),
        .op_a   (cmd_a),
        .op_b   (cmd_b),
        .res_hi (div_hi),
        .res_lo (div_lo)
    );

    hilo_file #(.W(DATA_W)) u_hilo (
        .clk     (clk),
        .rst     (rst),
        .pair_we (finish),
        .pair_hi (res_hi),
        .pair_lo (res_lo),
        .hi_we   (cmd.put_hi),
        .lo_we   (cmd.put_lo),
        .mv_data (cmd_a),
        .hi_q    (hi_q),
        .lo_q    (lo_q)
    );

    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(cnt_q) == LAST))
        else $error("busy dropped before the last iteration");

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt_q == '0))
        else $error("accepted start did not restart the count");

    // R5
    no_read_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_ready)
        else $error("move-from served while busy");

    // R6
    put_hi_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.put_hi |=> (hi_q == $past(cmd_a)))
        else $error("move-to HI did not land");

endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_func = '0;
    logic [31:0] cmd_a = '0;
    logic [31:0] cmd_b = '0;
    logic        busy, rd_ready, rd_stall;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    muldiv_unit #(.DATA_W(32)) u_muldiv_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy), .rd_ready(rd_ready),
        .rd_stall(rd_stall), .rd_data(rd_data)
    );

    int nchk = 0;
    int nfail = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [31:0] m_hi = '0, m_lo = '0, p_hi = '0, p_lo = '0;
    int          left = 0;
    bit          m_busy = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic ref_calc(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                            output logic [31:0] hi, output logic [31:0] lo);
        longint sa, sb, sp, sq, sr;
        logic [63:0] up;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        hi = '0; lo = '0;
        case (f)
            6'd24: begin sp = sa * sb; hi = sp[63:32]; lo = sp[31:0]; end
            6'd25: begin up = {32'b0, a} * {32'b0, b}; hi = up[63:32]; lo = up[31:0]; end
            6'd26: begin
                if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
                else begin sq = sa / sb; sr = sa % sb; hi = sr[31:0]; lo = sq[31:0]; end
            end
            6'd27: begin
                if (b == 0) begin hi = a; lo = 32'hFFFF_FFFF; end
                else begin hi = a % b; lo = a / b; end
            end
            default: ;
        endcase
    endtask

    task automatic cyc(input bit v, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        bit mf, st;
        bit e_ready, e_stall;
        logic [31:0] e_data;
        cmd_valid = v; cmd_func = f; cmd_a = a; cmd_b = b;
        #1;
        mf = v && (f == 6'd16 || f == 6'd18);
        e_ready = mf && !m_busy;
        e_stall = mf && m_busy;
        e_data  = e_ready ? ((f == 6'd16) ? m_hi : m_lo) : 32'h0;
        chk("R4 busy", {31'b0, busy}, {31'b0, m_busy});
        chk("R5 ready", {31'b0, rd_ready}, {31'b0, e_ready});
        chk("R5 stall", {31'b0, rd_stall}, {31'b0, e_stall});
        chk({cur_req, " data"}, rd_data, e_data);
        @(posedge clk);
        st = v && (f >= 6'd24 && f <= 6'd27);
        if (m_busy && !st) begin
            left--;
            if (left == 0) begin m_hi = p_hi; m_lo = p_lo; m_busy = 1'b0; end
        end
        if (st) begin ref_calc(f, a, b, p_hi, p_lo); left = 32; m_busy = 1'b1; end
        if (v && f == 6'd17) m_hi = a;
        if (v && f == 6'd19) m_lo = a;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 6'd0, 32'h0, 32'h0);
    endtask

    task automatic read_both();
        cyc(1'b1, 6'd16, 32'h0, 32'h0);
        cyc(1'b1, 6'd18, 32'h0, 32'h0);
    endtask

    task automatic run_op(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        cyc(1'b1, f, a, b);
        idle(32);
        read_both();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        read_both();

        cur_req = "R6";
        cyc(1'b1, 6'd17, 32'h1234_5678, 32'hDEAD_BEEF);
        read_both();
        cyc(1'b1, 6'd19, 32'h9ABC_DEF0, 32'h0);
        read_both();

        cur_req = "R2";
        run_op(6'd24, 32'hFFFF_FFF9, 32'd3);
        run_op(6'd24, 32'h8000_0000, 32'h8000_0000);
        run_op(6'd24, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(6'd25, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(6'd25, 32'd123456, 32'd789012);
        run_op(6'd24, 32'h7FFF_FFFF, 32'h8000_0001);

        cur_req = "R3";
        run_op(6'd26, 32'hFFFF_FFF9, 32'd2);
        run_op(6'd26, 32'd7, 32'hFFFF_FFFE);
        run_op(6'd27, 32'hFFFF_FFF9, 32'd2);
        run_op(6'd26, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(6'd27, 32'd5, 32'd9);

        cur_req = "R7";
        run_op(6'd26, 32'hFFFF_0123, 32'd0);
        run_op(6'd27, 32'h0000_4567, 32'd0);

        cur_req = "R5";
        cyc(1'b1, 6'd25, 32'd1000, 32'd3000);
        for (int i = 0; i < 32; i++) cyc(1'b1, (i % 2 == 0) ? 6'd16 : 6'd18, 32'h0, 32'h0);
        read_both();

        cur_req = "R8";
        cyc(1'b1, 6'd24, 32'd55, 32'd66);
        idle(10);
        cyc(1'b1, 6'd27, 32'd1000, 32'd7);
        idle(31);
        cyc(1'b1, 6'd24, 32'd9, 32'd9);
        idle(32);
        read_both();

        cur_req = "R4";
        cyc(1'b1, 6'd25, 32'd2, 32'd3);
        idle(31);
        cyc(1'b1, 6'd16, 32'h0, 32'h0);
        read_both();

        cur_req = "R6";
        cyc(1'b1, 6'd25, 32'hFFFF_FFFF, 32'd16);
        idle(31);
        cyc(1'b1, 6'd17, 32'hCAFE_0001, 32'h0);
        read_both();

        cur_req = "R9";
        cyc(1'b1, 6'd0, 32'h1111_1111, 32'h2);
        cyc(1'b1, 6'd20, 32'h2222_2222, 32'h3);
        cyc(1'b0, 6'd17, 32'h3333_3333, 32'h0);
        cyc(1'b0, 6'd24, 32'h4, 32'h5);
        read_both();

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=timeout exp=completion");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule